// File: doc/BRIEF.md
# I2C Interrupt Flag Aggregator

This block gathers the event sources of an I2C controller into one sticky interrupt-pending flag and a level interrupt request. The controller's own engines raise single-cycle pulses when a byte transfer completes, when a slave address of any kind matches, when arbitration is lost, when an SMBus timeout of some kind expires, and when a stop condition is seen on the bus. Each qualifying pulse sets the pending flag on the next clock edge. Software clears the flag by writing 1 to its bit in the status register.

A second sticky flag records stop detection. It sets on every stop, but it only feeds the pending flag when the stop-interrupt enable is 1. While the stop flag and that enable are both 1, the pending flag is re-armed on every cycle. Software must therefore write 1 to the stop flag first and to the pending flag second. If it clears them in the opposite order, the interrupt comes back at once.

The address-match input has one bit per match kind. The timeout input has one bit per timeout kind, and two of those kinds are ignored on purpose. The request output is the pending flag gated by a global interrupt enable.

Top module: `i2c_event_irq`

## Requirements
- R1: After reset, `pend_o`, `stop_flag_o` and `irq_o` are all 0.
- R2: A pulse on `evt_byte_done_i` or on `evt_arb_lost_i` makes `pend_o` 1 on the following clock edge.
- R3: A pulse on any bit of `evt_addr_hit_i` makes `pend_o` 1 on the following edge. The bits are: bit 0 primary address, bit 1 address range, bit 2 alert response, bit 3 second address, bit 4 general call.
- R4: `evt_tmo_i` bit 0 (clock held low) and bit 3 (extended clock stretch) set `pend_o` on the following edge. Bit 1 (SCL held high) and bit 2 (SDA held high) never set it.
- R5: `stop_flag_o` sets on the edge after every `evt_stop_i` pulse, whatever the value of `stop_irq_en_i`. It is cleared by a cycle with `filt_wr_i`=1 and `filt_stop_wd_i`=1. A write with `filt_stop_wd_i`=0 leaves it unchanged.
- R6: A stop pulse sets `pend_o` only when `stop_irq_en_i` is 1.
- R7: `pend_o` is cleared by a cycle with `stat_wr_i`=1 and `stat_pend_wd_i`=1. A write with data 0 leaves it unchanged. A qualifying event in the same cycle as a clear leaves it at 1.
- R8: While `stop_flag_o` and `stop_irq_en_i` are both 1, `pend_o` is 1 on the next edge. This holds even straight after a pending-flag clear, and also when the enable is raised after the stop. Clearing the stop flag first and the pending flag second leaves `pend_o` at 0.
- R9: `irq_o` is 1 exactly when `pend_o` and `irq_en_i` are both 1. It follows `irq_en_i` in the same cycle.
- R10: A stop pulse in the same cycle as a stop-flag clear leaves `stop_flag_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_byte_done_i | input | 1 | Byte transfer complete pulse |
| evt_addr_hit_i | input | N_ADDR (5) | Address match pulse, one bit per match kind |
| evt_arb_lost_i | input | 1 | Arbitration lost pulse |
| evt_tmo_i | input | N_TMO (4) | SMBus timeout pulse, one bit per timeout kind |
| evt_stop_i | input | 1 | Stop condition detected pulse |
| stop_irq_en_i | input | 1 | Lets stop detection raise the pending flag |
| irq_en_i | input | 1 | Global interrupt enable |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_pend_wd_i | input | 1 | Written value of the pending-flag bit |
| filt_wr_i | input | 1 | Glitch-filter register write strobe |
| filt_stop_wd_i | input | 1 | Written value of the stop-flag bit |
| pend_o | output | 1 | Sticky interrupt-pending flag |
| stop_flag_o | output | 1 | Sticky stop-detected flag |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check these rules: each qualifying pulse raises its flag one edge later, a flag stays set unless a write of 1 reaches it, a held stop flag with the enable set re-arms the pending flag, the pending flag never rises without a live source, and the request never appears without both the flag and the enable. Some effects can only be shown by a sequence of steps in the bench's scenarios. These are the order in which the two flags are cleared, the ignored timeout kinds leaving both flags low, the stop enable being raised after a stop has already been latched, and set winning over a clear in the same cycle.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  // Address match kinds, one request line each.
  localparam int unsigned ADDR_KINDS = 5;
  // SMBus timeout kinds, one request line each.
  localparam int unsigned TMO_KINDS  = 4;

  typedef enum int unsigned {
    TMO_CLK_LOW  = 0,
    TMO_SCL_HIGH = 1,
    TMO_SDA_HIGH = 2,
    TMO_STRETCH  = 3
  } tmo_kind_e;

  // Timeout kinds that must never raise the pending flag.
  localparam logic [TMO_KINDS-1:0] TMO_IGNORE_DEF =
    (TMO_KINDS'(1) << TMO_SCL_HIGH) | (TMO_KINDS'(1) << TMO_SDA_HIGH);
endpackage

// File: rtl/i2c_irq_src_qual.sv
module i2c_irq_src_qual #(
  parameter int unsigned     N_ADDR     = 5,
  parameter int unsigned     N_TMO      = 4,
  parameter logic [N_TMO-1:0] TMO_IGNORE = '0
) (
  input  logic              byte_done_i,
  input  logic [N_ADDR-1:0] addr_hit_i,
  input  logic              arb_lost_i,
  input  logic [N_TMO-1:0]  tmo_i,
  input  logic              stop_i,
  input  logic              stop_en_i,
  output logic              set_o
);
  logic [N_TMO-1:0] tmo_live;

  // Mask the timeout kinds that are not interrupt sources.
  for (genvar g = 0; g < N_TMO; g++) begin : g_tmo
    if (TMO_IGNORE[g]) begin : g_drop
      assign tmo_live[g] = 1'b0;
    end else begin : g_keep
      assign tmo_live[g] = tmo_i[g];
    end
  end

  always_comb begin
    set_o = byte_done_i
          | (|addr_hit_i)
          | arb_lost_i
          | (|tmo_live)
          | (stop_i & stop_en_i);
  end
endmodule

// File: rtl/i2c_irq_w1c_flag.sv
module i2c_irq_w1c_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic q_o
);
  logic clr;
  logic en;
  logic d;
  logic q;

  // A set in the same cycle as a clear wins.
  always_comb begin
    clr = wr_i & wdata_i;
    en  = set_i | clr;
    d   = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= 1'b0;
    end else if (en) begin
      q <= d;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/i2c_event_irq.sv
module i2c_event_irq #(
  parameter int unsigned      N_ADDR     = i2c_irq_pkg::ADDR_KINDS,
  parameter int unsigned      N_TMO      = i2c_irq_pkg::TMO_KINDS,
  parameter logic [N_TMO-1:0] TMO_IGNORE = i2c_irq_pkg::TMO_IGNORE_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_byte_done_i,
  input  logic [N_ADDR-1:0] evt_addr_hit_i,
  input  logic              evt_arb_lost_i,
  input  logic [N_TMO-1:0]  evt_tmo_i,
  input  logic              evt_stop_i,
  input  logic              stop_irq_en_i,
  input  logic              irq_en_i,
  input  logic              stat_wr_i,
  input  logic              stat_pend_wd_i,
  input  logic              filt_wr_i,
  input  logic              filt_stop_wd_i,
  output logic              pend_o,
  output logic              stop_flag_o,
  output logic              irq_o
);
  logic evt_set;
  logic stop_q;
  logic pend_q;
  logic pend_set;

  i2c_irq_src_qual #(
    .N_ADDR    (N_ADDR),
    .N_TMO     (N_TMO),
    .TMO_IGNORE(TMO_IGNORE)
  ) i_src_qual (
    .byte_done_i(evt_byte_done_i),
    .addr_hit_i (evt_addr_hit_i),
    .arb_lost_i (evt_arb_lost_i),
    .tmo_i      (evt_tmo_i),
    .stop_i     (evt_stop_i),
    .stop_en_i  (stop_irq_en_i),
    .set_o      (evt_set)
  );

  // The stop flag records every stop, enabled or not.
  i2c_irq_w1c_flag i_stop_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_stop_i),
    .wr_i   (filt_wr_i),
    .wdata_i(filt_stop_wd_i),
    .q_o    (stop_q)
  );

  // A held stop flag with its enable keeps re-arming the pending flag.
  always_comb begin
    pend_set = evt_set | (stop_q & stop_irq_en_i);
  end

  i2c_irq_w1c_flag i_pend_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pend_set),
    .wr_i   (stat_wr_i),
    .wdata_i(stat_pend_wd_i),
    .q_o    (pend_q)
  );

  always_comb begin
    pend_o      = pend_q;
    stop_flag_o = stop_q;
    irq_o       = pend_q & irq_en_i;
  end
endmodule

// File: rtl/i2c_event_irq_chk.sv
module i2c_event_irq_chk #(
  parameter int unsigned      N_ADDR     = 5,
  parameter int unsigned      N_TMO      = 4,
  parameter logic [N_TMO-1:0] TMO_IGNORE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_byte_done_i,
  input logic [N_ADDR-1:0] evt_addr_hit_i,
  input logic              evt_arb_lost_i,
  input logic [N_TMO-1:0]  evt_tmo_i,
  input logic              evt_stop_i,
  input logic              stop_irq_en_i,
  input logic              irq_en_i,
  input logic              stat_wr_i,
  input logic              stat_pend_wd_i,
  input logic              filt_wr_i,
  input logic              filt_stop_wd_i,
  input logic              pend_o,
  input logic              stop_flag_o,
  input logic              irq_o
);
  logic any_src;
  assign any_src = evt_byte_done_i | (|evt_addr_hit_i) | evt_arb_lost_i
                 | (|(evt_tmo_i & ~TMO_IGNORE))
                 | (stop_irq_en_i & (evt_stop_i | stop_flag_o));

  assert_byte_arb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_byte_done_i || evt_arb_lost_i) |=> pend_o);

  assert_addr_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_addr_hit_i) |=> pend_o);

  assert_tmo_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_tmo_i & ~TMO_IGNORE)) |=> pend_o);

  assert_no_spurious_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && !any_src) |=> !pend_o);

  assert_stop_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_stop_i |=> stop_flag_o);

  assert_stop_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_flag_o && !(filt_wr_i && filt_stop_wd_i)) |=> stop_flag_o);

  assert_stop_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_stop_i && stop_irq_en_i) |=> pend_o);

  assert_pend_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !(stat_wr_i && stat_pend_wd_i)) |=> pend_o);

  assert_rearm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_flag_o && stop_irq_en_i) |=> pend_o);

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_o && irq_en_i));

  assert_irq_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && irq_en_i) |-> irq_o);
endmodule

bind i2c_event_irq i2c_event_irq_chk #(
  .N_ADDR    (N_ADDR),
  .N_TMO     (N_TMO),
  .TMO_IGNORE(TMO_IGNORE)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .evt_byte_done_i(evt_byte_done_i),
  .evt_addr_hit_i (evt_addr_hit_i),
  .evt_arb_lost_i (evt_arb_lost_i),
  .evt_tmo_i      (evt_tmo_i),
  .evt_stop_i     (evt_stop_i),
  .stop_irq_en_i  (stop_irq_en_i),
  .irq_en_i       (irq_en_i),
  .stat_wr_i      (stat_wr_i),
  .stat_pend_wd_i (stat_pend_wd_i),
  .filt_wr_i      (filt_wr_i),
  .filt_stop_wd_i (filt_stop_wd_i),
  .pend_o         (pend_o),
  .stop_flag_o    (stop_flag_o),
  .irq_o          (irq_o)
);

// File: tb/test_i2c_event_irq.sv
module test_i2c_event_irq;
  localparam int unsigned NA = 5;
  localparam int unsigned NT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic byte_done, arb_lost, stop, stop_en, irq_en;
  logic [NA-1:0] addr_hit;
  logic [NT-1:0] tmo;
  logic stat_wr, stat_wd, filt_wr, filt_wd;
  logic pend, stop_flag, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_event_irq i_i2c_event_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_byte_done_i(byte_done), .evt_addr_hit_i(addr_hit),
    .evt_arb_lost_i(arb_lost), .evt_tmo_i(tmo), .evt_stop_i(stop),
    .stop_irq_en_i(stop_en), .irq_en_i(irq_en),
    .stat_wr_i(stat_wr), .stat_pend_wd_i(stat_wd),
    .filt_wr_i(filt_wr), .filt_stop_wd_i(filt_wd),
    .pend_o(pend), .stop_flag_o(stop_flag), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    byte_done = 0; arb_lost = 0; stop = 0; addr_hit = '0; tmo = '0;
    stat_wr = 0; stat_wd = 0; filt_wr = 0; filt_wd = 0;
  endtask

  // Inputs set before calling are held for one edge, then released.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic clr_pend();
    stat_wr = 1; stat_wd = 1; step();
  endtask

  task automatic clr_stop();
    filt_wr = 1; filt_wd = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 1'b0);
    chk("R1 stop", stop_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_byte_arb();
    byte_done = 1; step();
    chk("R2 byte", pend, 1'b1);
    chk("R9 irq on", irq, 1'b1);
    irq_en = 0; #1;
    chk("R9 irq gated", irq, 1'b0);
    irq_en = 1; #1;
    chk("R9 irq back", irq, 1'b1);
    clr_pend();
    chk("R7 clear", pend, 1'b0);
    chk("R9 irq off", irq, 1'b0);
    arb_lost = 1; step();
    chk("R2 arb", pend, 1'b1);
    stat_wr = 1; stat_wd = 0; step();
    chk("R7 write0", pend, 1'b1);
    stat_wr = 1; stat_wd = 1; byte_done = 1; step();
    chk("R7 set wins", pend, 1'b1);
    clr_pend();
    chk("R7 cleared", pend, 1'b0);
  endtask

  task automatic t_addr();
    for (int i = 0; i < NA; i++) begin
      addr_hit = NA'(1) << i; step();
      chk("R3 addr kind", pend, 1'b1);
      clr_pend();
    end
  endtask

  task automatic t_tmo();
    tmo = 4'b0110; step();
    step();
    chk("R4 ignored kinds", pend, 1'b0);
    chk("R4 ignored irq", irq, 1'b0);
    tmo = 4'b0001; step();
    chk("R4 clk low", pend, 1'b1);
    clr_pend();
    tmo = 4'b1000; step();
    chk("R4 stretch", pend, 1'b1);
    clr_pend();
    chk("R4 clean", pend, 1'b0);
  endtask

  task automatic t_stop_disabled();
    stop_en = 0;
    stop = 1; step();
    chk("R5 stop flag", stop_flag, 1'b1);
    chk("R6 no pend", pend, 1'b0);
    filt_wr = 1; filt_wd = 0; step();
    chk("R5 write0", stop_flag, 1'b1);
    // Raising the enable later re-arms the pending flag.
    stop_en = 1; step();
    chk("R8 late enable", pend, 1'b1);
    clr_stop();
    chk("R5 clear", stop_flag, 1'b0);
    clr_pend();
    chk("R8 ordered clear", pend, 1'b0);
  endtask

  task automatic t_stop_order();
    stop_en = 1;
    stop = 1; step();
    chk("R6 stop pend", pend, 1'b1);
    chk("R5 stop flag en", stop_flag, 1'b1);
    clr_pend();
    chk("R8 reversed rearm", pend, 1'b1);
    clr_stop();
    chk("R5 cleared", stop_flag, 1'b0);
    clr_pend();
    chk("R8 pend cleared", pend, 1'b0);
    stop = 1; step();
    clr_stop();
    clr_pend();
    chk("R8 right order", pend, 1'b0);
    step();
    chk("R8 stays low", pend, 1'b0);
    stop = 1; filt_wr = 1; filt_wd = 1; step();
    chk("R10 stop wins", stop_flag, 1'b1);
    clr_stop();
    clr_pend();
    chk("R10 cleanup", stop_flag, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    stop_en = 0; irq_en = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_byte_arb();
    t_addr();
    t_tmo();
    t_stop_disabled();
    t_stop_order();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule